// File: doc/BRIEF.md
# Multi-Channel Match PWM Timer

This block is a 32-bit up-counter paced by a 32-bit prescaler, compared every count against seven match values. Each match can raise a sticky interrupt flag, wrap the counter to zero or halt it. Match 0 normally defines the cycle period. Matches 1 to 6 drive six pulse outputs. Each output either rises at the cycle start and falls at its own match, or rises and falls on a pair of neighbouring matches, so that the pulse can be high-going or low-going.

Software reaches the block over a single-cycle synchronous write port and a combinational read port. In PWM mode a new match value goes into a shadow copy first. It moves into the compare path only when software has released it and the next cycle begins, so a period can never be cut by half-applied values. With PWM mode off the block is a plain match timer: the outputs stay low and match writes apply at once.

Top module: `pwm_timer`

## Requirements
- R1: While running, the count (read at address 2) rises by one every P+1 clocks, where P is the prescale limit at address 1; the prescale counter is readable at address 7.
- R2: The control register at address 0 holds run in bit 0, hold-in-reset in bit 1 and PWM mode in bit 2. With run clear, the count and prescale counter keep their value. With hold set, both are forced to zero whatever run says.
- R3: The action register at address 4 gives match i three bits at positions 3i (interrupt), 3i+1 (wrap) and 3i+2 (halt). On a count step where the count equals active match i and its wrap bit is set, the count goes to zero instead of rising, so a match-0 value M yields a period of M+1 counts.
- R4: On a count step where the count equals an active match whose halt bit is set, the count keeps that value and the run bit clears.
- R5: Flag bit i at address 3 sets when match i hits with its interrupt bit set. It stays set until a 1 is written to that bit, and writing 0 leaves it unchanged. The irq output is high while any flag is set.
- R6: An output k (pwm_out[k-1], k = 1..6) whose select bit k-1 at address 5 is 0 is high from count 0 through the count equal to match k and low afterwards. A match k equal to match 0 keeps it constantly low.
- R7: An output whose select bit is 1 goes high after the count reaches match k-1 and low after it reaches match k. Either order is allowed, giving a high-going or a low-going pulse. When both fall on one count, low wins.
- R8: In PWM mode a write to address 8+i changes only the shadow value readable there. The active value readable at address 16+i stays put until latch bit i is set by writing 1 at address 6 and a cycle boundary (a match-0 hit with its wrap bit set) follows. The released values are copied at that boundary and all latch bits clear.
- R9: With PWM mode off, all outputs are low and a write to address 8+i appears in the active value at 16+i at once.
- R10: After reset every register, the count, all outputs and irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 6 | Pulse outputs 1 to 6 |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The hardest case to reach is the release path. A shadow value has to sit unreleased across several full periods, then be released at an unknown phase of the cycle and be seen to take effect only at the following boundary, while the outputs keep their old shape in between. The stimulus loads a running pattern, rewrites one match to equal the period, and reads back the active and shadow copies before and after the latch write. It then samples the outputs every cycle against a model driven by the observed count, which also covers a high-going and a low-going double-edge pulse in the same period.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int CNT_W   = 32;
    localparam int N_MATCH = 7;
    localparam int ADDR_W  = 5;

    // register word addresses
    localparam int A_CTRL   = 0;
    localparam int A_PRESC  = 1;
    localparam int A_COUNT  = 2;
    localparam int A_FLAGS  = 3;
    localparam int A_ACTION = 4;
    localparam int A_SELECT = 5;
    localparam int A_LATCH  = 6;
    localparam int A_PCOUNT = 7;
    localparam int A_SHADOW = 8;
    localparam int A_ACTIVE = 16;

    typedef struct packed {
        logic pwm_mode;
        logic cnt_rst;
        logic cnt_en;
    } ctrl_t;

    typedef struct packed {
        logic halt;
        logic wrap;
        logic intr;
    } mact_t;

    localparam int MACT_W = $bits(mact_t);
    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic edge_next(input logic cur, input logic set, input logic clr);
        return clr ? 1'b0 : (set ? 1'b1 : cur);
    endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          hold,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          tick
);
    assign tick = run && !hold && (count >= limit);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            count <= '0;
        end else if (run) begin
            count <= (count >= limit) ? '0 : count + 1'b1;
        end
    end

    AST_PRESC_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!run && !hold) |=> $stable(count)); // R2
endmodule

// File: rtl/pwmt_match_bank.sv
module pwmt_match_bank #(
    parameter int CW = 32,
    parameter int NM = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CW-1:0]          tc,
    input  logic                   tick,
    input  logic                   pwm_mode,
    input  logic                   cycle_wrap,
    input  logic [NM-1:0]          wr_match,
    input  logic [CW-1:0]          wdata,
    input  logic [NM-1:0]          latch_set,
    output logic [NM-1:0][CW-1:0]  shadow_q,
    output logic [NM-1:0][CW-1:0]  active_q,
    output logic [NM-1:0]          latch_q,
    output logic [NM-1:0]          hit
);
    logic boundary;

    for (genvar i = 0; i < NM; i++) begin : g_cmp
        assign hit[i] = tick && (tc == active_q[i]);
    end

    assign boundary = pwm_mode && hit[0] && cycle_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            latch_q  <= '0;
        end else begin
            for (int i = 0; i < NM; i++) begin
                if (wr_match[i]) shadow_q[i] <= wdata;
                if (wr_match[i] && !pwm_mode) begin
                    active_q[i] <= wdata;
                end else if (boundary && latch_q[i]) begin
                    active_q[i] <= shadow_q[i];
                end
            end
            latch_q <= (boundary ? '0 : latch_q) | latch_set;
        end
    end

    AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (boundary && (latch_set == '0)) |=> (latch_q == '0)); // R8
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && !boundary) |=> $stable(active_q)); // R8
endmodule

// File: rtl/pwmt_out_logic.sv
module pwmt_out_logic
    import pwmt_pkg::*;
#(
    parameter int NM = 7,
    localparam int NOUT = NM - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwm_mode,
    input  logic [NM-1:0]   hit,
    input  logic [NOUT-1:0] dbl_sel,
    output logic [NOUT-1:0] pwm_q
);
    logic [NOUT-1:0] set_ev, clr_ev;

    for (genvar k = 1; k <= NOUT; k++) begin : g_chan
        assign set_ev[k-1] = dbl_sel[k-1] ? hit[k-1] : hit[0];
        assign clr_ev[k-1] = hit[k];

        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
            (pwm_mode && hit[k]) |=> !pwm_q[k-1]); // R7
    end

    always_ff @(posedge clk) begin
        if (rst || !pwm_mode) begin
            pwm_q <= '0;
        end else begin
            for (int k = 0; k < NOUT; k++) begin
                pwm_q[k] <= edge_next(pwm_q[k], set_ev[k], clr_ev[k]);
            end
        end
    end

    AST_PWM_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pwm_mode |=> (pwm_q == '0)); // R9
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NM = N_MATCH,
    parameter int AW = ADDR_W,
    localparam int NOUT = NM - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [CW-1:0]   bus_wdata,
    output logic [CW-1:0]   bus_rdata,
    output logic [NOUT-1:0] pwm_out,
    output logic            irq
);
    ctrl_t                 ctrl_q;
    logic [CW-1:0]         presc_q, tc_q, pc;
    logic [MACT_W*NM-1:0]  action_q;
    logic [NOUT-1:0]       dsel_q;
    logic [NM-1:0]         flags_q;
    logic                  tick;
    logic [NM-1:0]         hit, latch_q, wr_match, latch_set;
    logic [NM-1:0]         act_irq, act_wrap, act_halt;
    logic [NM-1:0][CW-1:0] shadow_q, active_q;
    logic                  wrap_hit, halt_hit;
    logic wr_ctrl, wr_presc, wr_flags, wr_action, wr_dsel, wr_latch;

    assign wr_ctrl   = bus_we && (bus_addr == AW'(A_CTRL));
    assign wr_presc  = bus_we && (bus_addr == AW'(A_PRESC));
    assign wr_flags  = bus_we && (bus_addr == AW'(A_FLAGS));
    assign wr_action = bus_we && (bus_addr == AW'(A_ACTION));
    assign wr_dsel   = bus_we && (bus_addr == AW'(A_SELECT));
    assign wr_latch  = bus_we && (bus_addr == AW'(A_LATCH));
    assign latch_set = wr_latch ? bus_wdata[NM-1:0] : '0;

    for (genvar i = 0; i < NM; i++) begin : g_match
        mact_t a_i;
        assign a_i         = mact_t'(action_q[MACT_W*i +: MACT_W]);
        assign act_irq[i]  = a_i.intr;
        assign act_wrap[i] = a_i.wrap;
        assign act_halt[i] = a_i.halt;
        assign wr_match[i] = bus_we && (bus_addr == AW'(A_SHADOW + i));
    end

    assign wrap_hit = |(hit & act_wrap);
    assign halt_hit = |(hit & act_halt);

    pwmt_prescaler #(.CW(CW)) u_presc (
        .clk(clk), .rst(rst), .run(ctrl_q.cnt_en), .hold(ctrl_q.cnt_rst),
        .limit(presc_q), .count(pc), .tick(tick)
    );

    pwmt_match_bank #(.CW(CW), .NM(NM)) u_bank (
        .clk(clk), .rst(rst), .tc(tc_q), .tick(tick), .pwm_mode(ctrl_q.pwm_mode),
        .cycle_wrap(act_wrap[0]), .wr_match(wr_match), .wdata(bus_wdata),
        .latch_set(latch_set), .shadow_q(shadow_q), .active_q(active_q),
        .latch_q(latch_q), .hit(hit)
    );

    pwmt_out_logic #(.NM(NM)) u_out (
        .clk(clk), .rst(rst), .pwm_mode(ctrl_q.pwm_mode), .hit(hit),
        .dbl_sel(dsel_q), .pwm_q(pwm_out)
    );

    always_ff @(posedge clk) begin
        if (rst || ctrl_q.cnt_rst) begin
            tc_q <= '0;
        end else if (tick) begin
            if (wrap_hit)      tc_q <= '0;
            else if (!halt_hit) tc_q <= tc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            presc_q  <= '0;
            action_q <= '0;
            dsel_q   <= '0;
            flags_q  <= '0;
        end else begin
            if (wr_ctrl)              ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            else if (tick && halt_hit) ctrl_q.cnt_en <= 1'b0;
            if (wr_presc)  presc_q  <= bus_wdata;
            if (wr_action) action_q <= bus_wdata[MACT_W*NM-1:0];
            if (wr_dsel)   dsel_q   <= bus_wdata[NOUT-1:0];
            flags_q <= (flags_q & ~(wr_flags ? bus_wdata[NM-1:0] : '0)) | (hit & act_irq);
        end
    end

    assign irq = |flags_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_CTRL):   bus_rdata = CW'(ctrl_q);
            AW'(A_PRESC):  bus_rdata = presc_q;
            AW'(A_COUNT):  bus_rdata = tc_q;
            AW'(A_FLAGS):  bus_rdata = CW'(flags_q);
            AW'(A_ACTION): bus_rdata = CW'(action_q);
            AW'(A_SELECT): bus_rdata = CW'(dsel_q);
            AW'(A_LATCH):  bus_rdata = CW'(latch_q);
            AW'(A_PCOUNT): bus_rdata = pc;
            default:       bus_rdata = '0;
        endcase
        for (int i = 0; i < NM; i++) begin
            if (bus_addr == AW'(A_SHADOW + i)) bus_rdata = shadow_q[i];
            if (bus_addr == AW'(A_ACTIVE + i)) bus_rdata = active_q[i];
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap_hit) |=> (tc_q == '0)); // R3
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tick && halt_hit && !wrap_hit && !wr_ctrl) |=> (!ctrl_q.cnt_en && $stable(tc_q))); // R4
    AST_COUNT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.cnt_en && !ctrl_q.cnt_rst) |=> $stable(tc_q)); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R5
endmodule

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
    localparam logic [4:0] AD_CTRL = 5'd0, AD_PRESC = 5'd1, AD_COUNT = 5'd2, AD_FLAGS = 5'd3;
    localparam logic [4:0] AD_ACTION = 5'd4, AD_SELECT = 5'd5, AD_LATCH = 5'd6, AD_PCOUNT = 5'd7;
    localparam logic [4:0] AD_SHADOW = 5'd8, AD_ACTIVE = 5'd16;
    localparam int SEL_RD = 0, SEL_PWM = 1, SEL_IRQ = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  pwm_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    event  mon_ev;

    logic [31:0] mv [7];
    logic [5:0]  ds;

    always #10 clk = ~clk;

    pwm_timer u_pwm_timer (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
    );

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = (it.sel == SEL_RD)  ? bus_rdata :
                      (it.sel == SEL_PWM) ? {26'b0, pwm_out} : {31'b0, irq};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_exp(input string tag, input int sel, input logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        ->mon_ev;
        #1;
    endtask

    task automatic expect_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        push_exp(tag, SEL_RD, exp);
    endtask

    // called in the low phase; the write lands on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic logic [5:0] model_pwm(input logic [31:0] t);
        logic [5:0] r;
        for (int k = 1; k <= 6; k++) begin
            logic [31:0] s, c;
            s = mv[k-1];
            c = mv[k];
            if (ds[k-1]) begin
                if (s < c)      r[k-1] = (t > s) && (t <= c);
                else if (c < s) r[k-1] = !((t > c) && (t <= s));
                else            r[k-1] = 1'b0;
            end else begin
                if (c == mv[0])     r[k-1] = 1'b0;
                else if (c > mv[0]) r[k-1] = 1'b1;
                else                r[k-1] = (t <= c);
            end
        end
        return r;
    endfunction

    task automatic sample_pwm(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] t;
            @(negedge clk);
            bus_addr = AD_COUNT;
            #1;
            t = bus_rdata;
            push_exp(tag, SEL_PWM, {26'b0, model_pwm(t)});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        expect_reg("R10 control after reset", AD_CTRL, 0);
        expect_reg("R10 count after reset", AD_COUNT, 0);
        push_exp("R10 outputs after reset", SEL_PWM, 0);
        push_exp("R10 irq after reset", SEL_IRQ, 0);

        // R1 prescaler pacing, R2 freeze and hold
        wr(AD_PRESC, 3);
        wr(AD_CTRL, 1);
        repeat (40) @(negedge clk);
        wr(AD_CTRL, 0);
        expect_reg("R1 count after 40 clocks at limit 3", AD_COUNT, 10);
        expect_reg("R1 prescale count", AD_PCOUNT, 1);
        repeat (5) @(negedge clk);
        expect_reg("R2 count frozen with run clear", AD_COUNT, 10);
        expect_reg("R2 prescale frozen with run clear", AD_PCOUNT, 1);
        wr(AD_CTRL, 2);
        @(negedge clk);
        expect_reg("R2 hold zeroes count", AD_COUNT, 0);
        expect_reg("R2 hold zeroes prescale", AD_PCOUNT, 0);
        wr(AD_CTRL, 3);
        repeat (6) @(negedge clk);
        expect_reg("R2 hold wins over run", AD_COUNT, 0);
        wr(AD_CTRL, 0);
        wr(AD_PRESC, 0);

        // R3 wrap on match 0, R5 flags, R9 direct write in timer mode
        wr(AD_SHADOW + 5'd0, 4);
        expect_reg("R9 timer-mode write reaches active", AD_ACTIVE + 5'd0, 4);
        wr(AD_ACTION, 32'h3);
        wr(AD_CTRL, 1);
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            expect_reg("R3 count sequence with period 5", AD_COUNT, i % 5);
        end
        expect_reg("R5 flag 0 set", AD_FLAGS, 1);
        push_exp("R5 irq high", SEL_IRQ, 1);
        wr(AD_CTRL, 0);
        wr(AD_FLAGS, 32'h7E);
        expect_reg("R5 writing other bits keeps flag", AD_FLAGS, 1);
        wr(AD_FLAGS, 32'h1);
        expect_reg("R5 write one clears flag", AD_FLAGS, 0);
        push_exp("R5 irq low after clear", SEL_IRQ, 0);

        // R4 halt on match 1
        wr(AD_SHADOW + 5'd0, 20);
        wr(AD_SHADOW + 5'd1, 7);
        wr(AD_ACTION, 32'h2A);
        wr(AD_CTRL, 2);
        wr(AD_CTRL, 1);
        repeat (30) @(negedge clk);
        expect_reg("R4 run bit cleared by halt", AD_CTRL, 0);
        expect_reg("R4 count holds match value", AD_COUNT, 7);
        expect_reg("R5 only interrupt-enabled match flagged", AD_FLAGS, 2);
        wr(AD_FLAGS, 32'h2);

        // R6 R7 pulse shapes
        mv[0] = 9; mv[1] = 3; mv[2] = 6; mv[3] = 2; mv[4] = 5; mv[5] = 8; mv[6] = 4;
        ds = 6'b101000;
        for (int i = 0; i < 7; i++) wr(AD_SHADOW + 5'(i), mv[i]);
        wr(AD_SELECT, {26'b0, ds});
        wr(AD_ACTION, 32'h2);
        wr(AD_CTRL, 2);
        wr(AD_CTRL, 5);
        repeat (12) @(negedge clk);
        sample_pwm("R6 R7 single and double edge pattern", 20);

        // R8 shadow, release and boundary copy
        wr(AD_SHADOW + 5'd2, 9);
        repeat (15) @(negedge clk);
        expect_reg("R8 active unchanged without release", AD_ACTIVE + 5'd2, 6);
        expect_reg("R8 shadow holds new value", AD_SHADOW + 5'd2, 9);
        sample_pwm("R8 R6 old pattern kept before release", 5);
        wr(AD_LATCH, 32'h4);
        expect_reg("R8 latch bit set", AD_LATCH, 4);
        expect_reg("R8 active unchanged before boundary", AD_ACTIVE + 5'd2, 6);
        repeat (25) @(negedge clk);
        expect_reg("R8 active copied at boundary", AD_ACTIVE + 5'd2, 9);
        expect_reg("R8 latch cleared at boundary", AD_LATCH, 0);
        mv[2] = 9;
        sample_pwm("R6 match equal to period gives constant low", 10);

        // R9 timer mode
        wr(AD_CTRL, 1);
        @(negedge clk);
        push_exp("R9 outputs low in timer mode", SEL_PWM, 0);
        @(negedge clk);
        push_exp("R9 outputs stay low in timer mode", SEL_PWM, 0);
        wr(AD_SHADOW + 5'd1, 5);
        expect_reg("R9 direct write of match 1", AD_ACTIVE + 5'd1, 5);

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule